// File: doc/BRIEF.md
# SPI flash command sequencer

This block is the master-side engine of an SPI NOR flash controller. It takes one request at a time (read a run of bytes, program a page, or erase a sector) and turns it into the byte frames the flash expects. It drives an external byte-wide SPI shifter one byte at a time and frames each transaction with one active-low chip select per attached chip. Program data comes in on a byte stream with valid/ready. Read data goes out as one `rd_valid` pulse per byte.

The engine does not wait for a program or erase to finish inside the flash. When such a command completes, it marks that chip busy and returns to idle at once. The next request to a marked chip first opens a status frame (opcode 0x05). It keeps clocking status bytes until bit 0 of a status byte is clear, then unmarks the chip and goes on with the real transaction. A chip that is not marked is never polled. Every program or erase has its own one-byte write-enable frame (0x06) before it. Chip select goes high for one SPI clock period (`SCK_DIV` system clocks) between frames of the same request. Reads use the plain read opcode 0x03, with no dummy byte.

The block must be built with `SCK_DIV` of at least 2.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, every `cs_n` line is high, `req_ready` is high and `done`, `rd_valid` and `sh_go` are low.
- R2: A request is taken only while `req_ready` is high (engine idle). A `req_valid` raised while a transaction runs produces no frame and is not queued.
- R3: Each command frame starts with a 4-byte header: the opcode, then address bits [23:16], [15:8] and [7:0]. The engine has at most one byte in flight at the shifter.
- R4: A read (`req_op` = 0) sends opcode 0x03 and then `req_len` filler bytes. Each received byte appears on `rd_data` with a one-cycle `rd_valid` pulse, in wire order.
- R5: A program (`req_op` = 1) sends a frame holding only 0x06, then a frame of 0x02, the address and `req_len` bytes taken in order from the `wr_data` stream.
- R6: An erase (`req_op` = 2) sends a frame holding only 0x06, then exactly 0xD8 and the 3 address bytes, whatever `req_len` is.
- R7: Once a program or erase finishes, the engine marks that chip busy and completes without any status frame in the same request.
- R8: The next request to a busy chip first sends a frame of 0x05 followed by status bytes, and closes it right after the first status byte with bit 0 clear. The chip is then unmarked, so a later request is not polled.
- R9: A chip that is not marked busy is not polled, even while another chip is marked.
- R10: Between two frames of one request, all `cs_n` lines stay high for at least `SCK_DIV` clock cycles.
- R11: `done` is a single-cycle pulse in the cycle after the `sh_done` of the last byte, with all chip selects high. For a read with data, it coincides with the last `rd_valid`.
- R12: `req_cs` is a one-hot mask in which bit i selects `cs_n[i]`. At most one `cs_n` is ever low, and it is the requested one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request taken this cycle if valid |
| req_op | input | 2 | 0 read, 1 program, 2 erase |
| req_addr | input | 24 | Flash byte address |
| req_len | input | LEN_W | Data byte count (ignored for erase) |
| req_cs | input | NCS | One-hot chip select mask |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data byte present |
| wr_ready | output | 1 | Program data byte taken this cycle if valid |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read data byte strobe |
| sh_go | output | 1 | Start shifting `sh_tx` |
| sh_tx | output | 8 | Byte to shift out |
| sh_done | input | 1 | Shifter finished the byte |
| sh_rx | input | 8 | Byte shifted in |
| cs_n | output | NCS | Active-low chip selects |
| done | output | 1 | Request complete pulse |

## Verification
The delivery of the last read byte and the completion pulse land in the same cycle. Every read vector with a non-zero length provokes this. The bench records whether `rd_valid` was high in the `done` cycle and compares the read bytes with the pattern its shifter model returned. The second pairing sets one chip busy and then accesses another. Here the bench judges from the frame log that one chip is polled while the other is left alone, and that the busy mark of the first survives until its own next access.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_POLL_OP, S_POLL_RD, S_WREN, S_GAP, S_HDR, S_DATA, S_FINISH
  } st_e;

  localparam logic [7:0] OPC_STATUS       = 8'h05;
  localparam logic [7:0] OPC_WR_EN        = 8'h06;
  localparam logic [7:0] OPC_READ         = 8'h03;
  localparam logic [7:0] OPC_PROGRAM      = 8'h02;
  localparam logic [7:0] OPC_SECTOR_ERASE = 8'hD8;
  localparam logic [7:0] FILL_BYTE        = 8'h00;

endpackage

// File: rtl/fsq_busy_track.sv
module fsq_busy_track #(
  parameter int NCS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_en,
  input  logic           clr_en,
  input  logic [NCS-1:0] sel,
  output logic [NCS-1:0] busy
);

  for (genvar i = 0; i < NCS; i++) begin : g_chip
    logic busy_d;
    always_comb begin
      busy_d = busy[i];
      if (set_en && sel[i])      busy_d = 1'b1;
      else if (clr_en && sel[i]) busy_d = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy[i] <= 1'b0;
      else        busy[i] <= busy_d;
    end
  end

  // R7 R8: marking and unmarking come from different phases of a request
  assert_set_clr_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && clr_en));

endmodule

// File: rtl/fsq_gap_timer.sv
module fsq_gap_timer #(
  parameter int SCK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic zero
);

  localparam int CW = (SCK_DIV > 2) ? $clog2(SCK_DIV) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(SCK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = LOAD_VAL;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R10: a freshly loaded gap never expires in the next cycle
  assert_gap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !zero);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int NCS     = 4,
  parameter int LEN_W   = 9,
  parameter int SCK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [NCS-1:0]   req_cs,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             sh_go,
  output logic [7:0]       sh_tx,
  input  logic             sh_done,
  input  logic [7:0]       sh_rx,
  output logic [NCS-1:0]   cs_n,
  output logic             done
);

  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      srst_n   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      srst_n   <= rst_meta;
    end
  end

  st_e              st_q, st_d, ret_q, ret_d;
  op_e              op_q, op_d;
  logic [23:0]      addr_q, addr_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [NCS-1:0]   mask_q, mask_d;
  logic [1:0]       idx_q, idx_d;
  logic             sent_q, sent_d;
  logic             rd_valid_q, rd_fire;
  logic [7:0]       rd_data_q;
  logic             busy_set, busy_clr, gap_load, gap_zero;
  logic [NCS-1:0]   busy_vec;
  logic             is_wr;
  logic [7:0]       hdr_byte, cmd_opc;

  fsq_busy_track #(.NCS(NCS)) u_busy (
    .clk(clk), .rst_n(srst_n), .set_en(busy_set), .clr_en(busy_clr),
    .sel(mask_q), .busy(busy_vec)
  );

  fsq_gap_timer #(.SCK_DIV(SCK_DIV)) u_gap (
    .clk(clk), .rst_n(srst_n), .load(gap_load), .zero(gap_zero)
  );

  assign is_wr = (op_q == OP_PROG) || (op_q == OP_ERASE);

  always_comb begin
    cmd_opc = OPC_READ;
    if (op_q == OP_PROG)  cmd_opc = OPC_PROGRAM;
    if (op_q == OP_ERASE) cmd_opc = OPC_SECTOR_ERASE;
    case (idx_q)
      2'd0:    hdr_byte = cmd_opc;
      2'd1:    hdr_byte = addr_q[23:16];
      2'd2:    hdr_byte = addr_q[15:8];
      default: hdr_byte = addr_q[7:0];
    endcase
  end

  // next-state logic
  always_comb begin
    st_d = st_q;  ret_d = ret_q;  op_d = op_q;  addr_d = addr_q;
    cnt_d = cnt_q;  mask_d = mask_q;  idx_d = idx_q;  sent_d = sent_q;
    sh_go = 1'b0;  sh_tx = FILL_BYTE;  wr_ready = 1'b0;  rd_fire = 1'b0;
    busy_set = 1'b0;  busy_clr = 1'b0;  gap_load = 1'b0;
    case (st_q)
      S_IDLE: if (req_valid) begin
        op_d   = op_e'(req_op);
        addr_d = req_addr;
        cnt_d  = req_len;
        mask_d = req_cs;
        idx_d  = 2'd0;
        sent_d = 1'b0;
        if ((busy_vec & req_cs) != '0)                   st_d = S_POLL_OP;
        else if (req_op == OP_PROG || req_op == OP_ERASE) st_d = S_WREN;
        else                                              st_d = S_HDR;
      end
      S_POLL_OP: begin
        sh_tx = OPC_STATUS;
        if (!sent_q) begin sh_go = 1'b1; sent_d = 1'b1; end
        else if (sh_done) begin sent_d = 1'b0; st_d = S_POLL_RD; end
      end
      S_POLL_RD: begin
        if (!sent_q) begin sh_go = 1'b1; sent_d = 1'b1; end
        else if (sh_done) begin
          sent_d = 1'b0;
          if (!sh_rx[0]) begin
            busy_clr = 1'b1;
            gap_load = 1'b1;
            st_d     = S_GAP;
            ret_d    = is_wr ? S_WREN : S_HDR;
          end
        end
      end
      S_WREN: begin
        sh_tx = OPC_WR_EN;
        if (!sent_q) begin sh_go = 1'b1; sent_d = 1'b1; end
        else if (sh_done) begin
          sent_d = 1'b0; gap_load = 1'b1; st_d = S_GAP; ret_d = S_HDR;
        end
      end
      S_GAP: if (gap_zero) st_d = ret_q;
      S_HDR: begin
        sh_tx = hdr_byte;
        if (!sent_q) begin sh_go = 1'b1; sent_d = 1'b1; end
        else if (sh_done) begin
          sent_d = 1'b0;
          idx_d  = idx_q + 2'd1;
          if (idx_q == 2'd3)
            st_d = (op_q == OP_ERASE || cnt_q == '0) ? S_FINISH : S_DATA;
        end
      end
      S_DATA: begin
        if (op_q == OP_PROG) begin
          wr_ready = !sent_q;
          sh_tx    = wr_data;
          if (!sent_q && wr_valid) begin sh_go = 1'b1; sent_d = 1'b1; end
        end else if (!sent_q) begin
          sh_go = 1'b1; sent_d = 1'b1;
        end
        if (sent_q && sh_done) begin
          sent_d  = 1'b0;
          cnt_d   = cnt_q - LEN_ONE;
          rd_fire = (op_q != OP_PROG);
          if (cnt_q == LEN_ONE) st_d = S_FINISH;
        end
      end
      S_FINISH: begin
        busy_set = is_wr;
        st_d     = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q <= S_IDLE;  ret_q <= S_HDR;  op_q <= OP_READ;  addr_q <= '0;
      cnt_q <= '0;  mask_q <= '0;  idx_q <= '0;  sent_q <= 1'b0;
      rd_valid_q <= 1'b0;  rd_data_q <= '0;
    end else begin
      st_q <= st_d;  ret_q <= ret_d;  op_q <= op_d;  addr_q <= addr_d;
      cnt_q <= cnt_d;  mask_q <= mask_d;  idx_q <= idx_d;  sent_q <= sent_d;
      rd_valid_q <= rd_fire;
      if (rd_fire) rd_data_q <= sh_rx;
    end
  end

  logic cs_act;
  assign cs_act    = (st_q == S_POLL_OP) || (st_q == S_POLL_RD) || (st_q == S_WREN) ||
                     (st_q == S_HDR) || (st_q == S_DATA);
  assign cs_n      = cs_act ? ~mask_q : '1;
  assign req_ready = (st_q == S_IDLE);
  assign done      = (st_q == S_FINISH);
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;

  // R12: never more than one chip selected
  assert_cs_onehot_R12: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(~cs_n));
  // R11: completion is a single pulse with the bus released
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!srst_n)
    done |=> !done);
  assert_done_cs_idle_R11: assert property (@(posedge clk) disable iff (!srst_n)
    done |-> (&cs_n));
  // R8: an idle status byte closes the status frame at once
  assert_poll_end_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q == S_POLL_RD && sent_q && sh_done && !sh_rx[0]) |=> (&cs_n));
  // R3: one byte in flight at the shifter
  assert_one_inflight_R3: assert property (@(posedge clk) disable iff (!srst_n)
    sh_go |=> !sh_go);
  // R2: a busy engine keeps its captured request
  assert_no_accept_R2: assert property (@(posedge clk) disable iff (!srst_n)
    !req_ready |=> $stable(addr_q));

endmodule

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;

  localparam int NCS = 4, LEN_W = 9, SCK_DIV = 4, LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [23:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [NCS-1:0] req_cs = '0;
  logic [7:0] wr_data;
  logic wr_valid = 1'b1, wr_ready;
  logic [7:0] rd_data;
  logic rd_valid, sh_go;
  logic [7:0] sh_tx;
  logic sh_done = 1'b0;
  logic [7:0] sh_rx = '0;
  logic [NCS-1:0] cs_n;
  logic done;

  always #2.5 clk = ~clk;

  flash_cmd_seq #(.NCS(NCS), .LEN_W(LEN_W), .SCK_DIV(SCK_DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len), .req_cs(req_cs),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .sh_go(sh_go), .sh_tx(sh_tx),
    .sh_done(sh_done), .sh_rx(sh_rx), .cs_n(cs_n), .done(done)
  );

  int tests = 0, fails = 0;

  // flash and shifter model with frame log
  logic [7:0] fb [0:7][0:23];
  int flen [0:7];
  int fchip [0:7];
  int nfr = 0, min_gap = 999, hi_cnt = 0, lat_cnt = 0, wr_idx = 0;
  int busy_left [0:NCS-1];
  bit prev_hi = 1'b1;
  int done_cnt = 0, rdn = 0;
  bit done_rv = 1'b0;
  logic [7:0] rdbuf [0:23];

  assign wr_data = 8'h30 + wr_idx[7:0];

  always @(posedge clk) begin
    bit all_hi;
    int f, pos;
    logic [7:0] rx;
    sh_done <= 1'b0;
    all_hi = &cs_n;
    if (!all_hi && prev_hi) begin
      if (nfr > 0 && hi_cnt < min_gap) min_gap = hi_cnt;
      if (nfr < 8) begin
        flen[nfr] = 0;
        for (int i = 0; i < NCS; i++) if (!cs_n[i]) fchip[nfr] = i;
      end
      nfr++;
    end
    if (all_hi) hi_cnt++; else hi_cnt = 0;
    prev_hi = all_hi;
    if (wr_valid && wr_ready) wr_idx++;
    if (sh_go) begin
      f = nfr - 1;
      if (f >= 0 && f < 8 && flen[f] < 24) begin
        fb[f][flen[f]] = sh_tx;
        flen[f]++;
      end
      lat_cnt = LAT;
    end else if (lat_cnt > 0) begin
      lat_cnt--;
      if (lat_cnt == 0) begin
        f = nfr - 1;
        rx = 8'hFF;
        if (f >= 0 && f < 8) begin
          pos = flen[f] - 1;
          if (fb[f][0] == 8'h05 && pos > 0) begin
            if (busy_left[fchip[f]] > 0) begin
              busy_left[fchip[f]]--;
              rx = 8'h01;
            end else rx = 8'h00;
          end else if (fb[f][0] == 8'h03 && pos >= 4) rx = 8'hC0 ^ pos[7:0];
        end
        sh_done <= 1'b1;
        sh_rx   <= rx;
      end
    end
  end

  always @(negedge clk) begin
    if (done) begin
      done_cnt++;
      done_rv = rd_valid;
    end
    if (rd_valid && rdn < 24) begin
      rdbuf[rdn] = rd_data;
      rdn++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkeq(input string tag, input longint act, input longint exp);
    chk(act == exp, tag, act, exp);
  endtask

  int wr_start;

  task automatic clear_log();
    nfr = 0; min_gap = 999; done_cnt = 0; rdn = 0; done_rv = 1'b0; wr_start = wr_idx;
  endtask

  task automatic wait_done();
    int t = 0;
    while (done_cnt == 0 && t < 3000) begin @(negedge clk); t++; end
    if (done_cnt == 0) chk(1'b0, "R11 request timed out", 0, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic run_req(input int op, input logic [23:0] addr, input int len, input int chip);
    @(negedge clk);
    clear_log();
    req_op = 2'(op); req_addr = addr; req_len = LEN_W'(len);
    req_cs = NCS'(1) << chip; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
  endtask

  task automatic verify(input int op, input logic [23:0] addr, input int len,
                        input int chip, input int polls, input bit wasbusy);
    int k = 0;
    logic [7:0] opc;
    if (wasbusy) begin
      chkeq("R8 status opcode", fb[0][0], 8'h05);
      chkeq("R8 status frame length", flen[0], polls + 2);
      k++;
    end else chk(fb[0][0] != 8'h05, "R9 idle chip was polled", fb[0][0], 0);
    if (op != 0) begin
      chkeq("R5 R6 write-enable opcode", fb[k][0], 8'h06);
      chkeq("R5 R6 write-enable frame length", flen[k], 1);
      k++;
    end
    opc = (op == 0) ? 8'h03 : (op == 1) ? 8'h02 : 8'hD8;
    chkeq("R3 command opcode", fb[k][0], opc);
    chkeq("R3 address bytes", {fb[k][1], fb[k][2], fb[k][3]}, addr);
    if (op == 2) chkeq("R6 erase frame length", flen[k], 4);
    else         chkeq("R4 R5 command frame length", flen[k], 4 + len);
    for (int j = 0; j < len; j++) begin
      if (op == 1) chkeq("R5 program byte", fb[k][4 + j], 8'(8'h30 + wr_start + j));
      if (op == 0) chkeq("R4 read byte", rdbuf[j], 8'hC0 ^ 8'(4 + j));
    end
    if (op == 0) chkeq("R4 rd_valid count", rdn, len);
    chkeq("R7 frame count", nfr, k + 1);
    for (int f = 0; f < nfr && f < 8; f++) chkeq("R12 selected chip", fchip[f], chip);
    if (nfr > 1) chk(min_gap >= SCK_DIV, "R10 deselect gap", min_gap, SCK_DIV);
    chkeq("R11 done pulses", done_cnt, 1);
    if (op == 0 && len > 0) chkeq("R11 done with last rd_valid", done_rv, 1);
  endtask

  // op, chip, len, polls, addr
  localparam logic [35:0] VEC [0:7] = '{
    {2'd0, 2'd0, 4'd3, 4'd0, 24'h123456},
    {2'd1, 2'd0, 4'd4, 4'd2, 24'h00AB00},
    {2'd0, 2'd0, 4'd2, 4'd2, 24'h0000FF},
    {2'd2, 2'd1, 4'd5, 4'd0, 24'h010000},
    {2'd0, 2'd2, 4'd1, 4'd0, 24'h7FFFFF},
    {2'd1, 2'd1, 4'd2, 4'd1, 24'h020010},
    {2'd2, 2'd3, 4'd0, 4'd0, 24'hFFFFFF},
    {2'd0, 2'd1, 4'd0, 4'd0, 24'h000001}
  };

  bit exp_busy [0:NCS-1];

  task automatic do_vec(input int op, input int chip, input int len, input int polls,
                        input logic [23:0] addr);
    busy_left[chip] = polls;
    run_req(op, addr, len, chip);
    verify(op, addr, len, chip, polls, exp_busy[chip]);
    if (exp_busy[chip]) exp_busy[chip] = 1'b0;
    if (op != 0) exp_busy[chip] = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCS; i++) begin busy_left[i] = 0; exp_busy[i] = 1'b0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chkeq("R1 cs_n idle", cs_n, {NCS{1'b1}});
    chkeq("R1 req_ready", req_ready, 1);
    chkeq("R1 done low", done, 0);
    chkeq("R1 rd_valid low", rd_valid, 0);
    chkeq("R1 sh_go low", sh_go, 0);

    for (int v = 0; v < 8; v++)
      do_vec(int'(VEC[v][35:34]), int'(VEC[v][33:32]), int'(VEC[v][31:28]),
             int'(VEC[v][27:24]), VEC[v][23:0]);

    // R2: request raised mid-transaction is dropped
    @(negedge clk);
    clear_log();
    busy_left[2] = 0;
    req_op = 2'd0; req_addr = 24'h00C0DE; req_len = LEN_W'(6); req_cs = 4'b0100;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (8) @(negedge clk);
    chkeq("R2 req_ready low while busy", req_ready, 0);
    req_op = 2'd2; req_cs = 4'b1000; req_addr = 24'h0F0F0F; req_valid = 1'b1;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    repeat (60) @(negedge clk);
    chkeq("R2 no extra frame", nfr, 1);
    chkeq("R2 frame kept read opcode", fb[0][0], 8'h03);
    chkeq("R2 read length kept", rdn, 6);

    // R8: long poll on chip 3, then the mark is gone
    do_vec(0, 3, 2, 3, 24'h300000);
    do_vec(0, 3, 1, 0, 24'h300100);
    chkeq("R8 busy cleared after poll", nfr, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule